// File: doc/BRIEF.md
# Horizontal Microcoded Sequencer for a Register-Add Datapath

This block is the control unit of a small multi-cycle datapath. It holds a 64-entry control store of 32-bit words and a micro-program counter that selects one word per clock. Each word is horizontal: every set bit drives one datapath strobe directly, with no decoding between the store and the pins. The stored routine fetches an instruction word and bumps the program counter by four. It then reads two source registers, adds them, and writes the sum back to a destination register. It then returns to fetch.

The block also holds the instruction register. It loads that register from the datapath's memory-data register only in the step that asks for it. From the register it presents the two source-register selects and the destination select, plus a write-address select that switches to the destination field during writeback. The datapath itself sits outside the block.

Top module: `ucode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the micro-program counter becomes 0, and for as long as `rst` is high both strobe buses read zero. A routine cut short by reset performs no further transfers and restarts at micro-address 0 once `rst` falls.
- R2: Exactly one control word is issued per clock. After a word with any bit set, the micro-program counter advances by one at the next edge.
- R3: A word with no bit set (address 8 and every unused address) returns the micro-program counter to 0 at the next edge.
- R4: For step k from 0 to 7, the word has bits 31−k and k set. The write-strobe bus `wr_en_o` carries word bits 31:24 and the source-strobe bus `src_en_o` carries word bits 7:0. The write-strobe bits are: bit 7 MAR load, bit 6 MDR load from memory, bit 5 IR load, bit 4 PC load, bit 3 A latch, bit 2 B latch, bit 1 ALU-result latch, bit 0 register-file write. The source-strobe bits are: bit 0 PC onto address, bit 1 memory read, bit 2 MDR onto IR, bit 3 ALU adds PC and constant 4, bit 4 read port at rs, bit 5 read port at rt, bit 6 ALU adds A and B, bit 7 write address from rd with the result taken from the ALU-result latch (never memory).
- R5: At most one write strobe is high in any cycle, and the number of source strobes equals the number of write strobes.
- R6: The instruction register takes `mdr_i` only at the edge that ends a cycle with `wr_en_o[5]` high. At every other edge it holds its value.
- R7: `rs_o` is IR[25:21], `rt_o` is IR[20:16], and `rd_o` is IR[15:11].
- R8: `wa_o` equals `rd_o` while `src_en_o[7]` is high, and equals `rt_o` otherwise.
- R9: One full routine on the attached datapath leaves Reg[rd] = Reg[rs] + Reg[rt] modulo 2^32 and the program counter four higher. This also holds when rs equals rt or when rd equals a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mdr_i | input | 32 | Memory-data register value from the datapath |
| upc_o | output | 6 | Current micro-program counter |
| wr_en_o | output | 8 | Register-load strobes (bit meanings in R4) |
| src_en_o | output | 8 | Source, read and ALU-mode strobes (bit meanings in R4) |
| rs_o | output | 5 | First source register select |
| rt_o | output | 5 | Second source register select |
| rd_o | output | 5 | Destination register select |
| wa_o | output | 5 | Register-file write address |

## Verification
The bench feeds `mdr_i` the inverted memory-data value in every cycle except the IR-load step. An IR that loads in the wrong step therefore produces wrong register selects and a wrong sum. Several instructions stress the datapath: one has rs equal to rt, one overwrites one of its own sources, and one wraps past 2^32. A sequencer that skips or repeats a step, or that misses the return at the empty word, shows up in the per-cycle strobe compare. A reset asserted in the middle of a routine checks that no writeback leaks out and that the next routine starts at fetch.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned STB_W  = 8;
  localparam int unsigned GAP_W  = WORD_W - 2 * STB_W;
  localparam int unsigned REG_AW = 5;

  typedef struct packed {
    logic [STB_W-1:0] wr;
    logic [GAP_W-1:0] gap;
    logic [STB_W-1:0] src;
  } uword_t;

  // Step k drives one bit from the top byte and one from the bottom byte.
  function automatic logic [WORD_W-1:0] uword_at(input int unsigned addr);
    logic [WORD_W-1:0] w;
    w = '0;
    if (addr < STB_W) begin
      w[WORD_W-1-addr] = 1'b1;
      w[addr]          = 1'b1;
    end
    return w;
  endfunction

endpackage

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output uword_t            word_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom[g] = uword_at(g);
  end

  assign word_o = uword_t'(rom[addr_i]);
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ret_i,
  output logic [ADDR_W-1:0] upc_o
);
  always_ff @(posedge clk) begin
    if (rst || ret_i) upc_o <= '0;
    else              upc_o <= upc_o + 1'b1;
  end
endmodule

// File: rtl/ucode_ir.sv
module ucode_ir
  import ucode_pkg::*;
#(
  parameter int unsigned RS_LSB = 21,
  parameter int unsigned RT_LSB = 16,
  parameter int unsigned RD_LSB = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] d_i,
  output logic [REG_AW-1:0] rs_o,
  output logic [REG_AW-1:0] rt_o,
  output logic [REG_AW-1:0] rd_o
);
  logic [WORD_W-1:0] ir_q;

  always_ff @(posedge clk) begin
    if (rst)         ir_q <= '0;
    else if (load_i) ir_q <= d_i;
  end

  assign rs_o = ir_q[RS_LSB +: REG_AW];
  assign rt_o = ir_q[RT_LSB +: REG_AW];
  assign rd_o = ir_q[RD_LSB +: REG_AW];

  // Opcode and function bits are held but not decoded by this control unit.
  logic unused_ir_bits;
  assign unused_ir_bits = ^{ir_q[WORD_W-1:RS_LSB+REG_AW], ir_q[RD_LSB-1:0]};
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucode_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORD_W-1:0]     mdr_i,
  output logic [ADDR_W-1:0]     upc_o,
  output logic [STB_W-1:0]      wr_en_o,
  output logic [STB_W-1:0]      src_en_o,
  output logic [REG_AW-1:0]     rs_o,
  output logic [REG_AW-1:0]     rt_o,
  output logic [REG_AW-1:0]     rd_o,
  output logic [REG_AW-1:0]     wa_o
);
  localparam int unsigned IR_LD_BIT = STB_W - 3;
  localparam int unsigned WB_RD_BIT = STB_W - 1;

  uword_t word;
  logic   word_empty;

  ucode_store #(.ADDR_W(ADDR_W)) u_store (
    .addr_i (upc_o),
    .word_o (word)
  );

  assign word_empty = (word == '0);

  ucode_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .ret_i (word_empty),
    .upc_o (upc_o)
  );

  assign wr_en_o  = rst ? '0 : word.wr;
  assign src_en_o = rst ? '0 : word.src;

  ucode_ir u_ir (
    .clk    (clk),
    .rst    (rst),
    .load_i (wr_en_o[IR_LD_BIT]),
    .d_i    (mdr_i),
    .rs_o   (rs_o),
    .rt_o   (rt_o),
    .rd_o   (rd_o)
  );

  assign wa_o = src_en_o[WB_RD_BIT] ? rd_o : rt_o;
endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] upc_o,
  input logic [7:0]        wr_en_o,
  input logic [7:0]        src_en_o,
  input logic [4:0]        rs_o,
  input logic [4:0]        rt_o,
  input logic [4:0]        rd_o,
  input logic [4:0]        wa_o
);
  // R1: strobes quiet during reset
  always_comb begin
    if (rst === 1'b1) begin
      p_quiet_in_reset_r1: assert (wr_en_o == '0 && src_en_o == '0);
    end
  end

  // R1: counter cleared by reset
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> upc_o == '0);

  // R2
  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o != '0) |=> upc_o == $past(upc_o) + 1'b1);

  // R3
  p_empty_returns_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o == '0 && src_en_o == '0) |=> upc_o == '0);

  // R5
  p_one_write_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en_o));

  // R5
  p_paired_strobes_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_en_o) == $countones(src_en_o));

  // R6
  p_ir_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en_o[5] |=> $stable({rs_o, rt_o, rd_o}));

  // R8
  p_wb_addr_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en_o[0] |-> wa_o == rd_o);
endmodule

bind ucode_ctrl ucode_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .upc_o    (upc_o),
  .wr_en_o  (wr_en_o),
  .src_en_o (src_en_o),
  .rs_o     (rs_o),
  .rt_o     (rt_o),
  .rd_o     (rd_o),
  .wa_o     (wa_o)
);

// File: tb/test_ucode_ctrl.sv
`timescale 1ns/1ps
module test_ucode_ctrl;
  localparam int NI = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mdr_i;
  logic [5:0]  upc_o;
  logic [7:0]  wr_en_o, src_en_o;
  logic [4:0]  rs_o, rt_o, rd_o, wa_o;

  always #2 clk = ~clk;

  ucode_ctrl i_ucode_ctrl (
    .clk(clk), .rst(rst), .mdr_i(mdr_i), .upc_o(upc_o),
    .wr_en_o(wr_en_o), .src_en_o(src_en_o),
    .rs_o(rs_o), .rt_o(rt_o), .rd_o(rd_o), .wa_o(wa_o)
  );

  // Behavioural datapath stub
  logic [31:0] pc, mar, mdr, a_q, b_q, alu_q;
  logic [31:0] regs [32];
  logic [31:0] imem [16];

  // Wrong data everywhere except the IR-load step
  assign mdr_i = wr_en_o[5] ? mdr : ~mdr;

  always @(posedge clk) begin
    if (!rst) begin
      if (wr_en_o[7] && src_en_o[0]) mar   <= pc;
      if (wr_en_o[6] && src_en_o[1]) mdr   <= imem[mar[5:2]];
      if (wr_en_o[4] && src_en_o[3]) pc    <= pc + 32'd4;
      if (wr_en_o[3] && src_en_o[4]) a_q   <= regs[rs_o];
      if (wr_en_o[2] && src_en_o[5]) b_q   <= regs[rt_o];
      if (wr_en_o[1] && src_en_o[6]) alu_q <= a_q + b_q;
      if (wr_en_o[0])                regs[wa_o] <= alu_q;
    end
  end

  // Scoreboard
  typedef struct {
    logic [4:0]  rd;
    logic [31:0] val;
    logic [31:0] pc;
  } sb_t;
  sb_t sbq[$];

  logic [31:0] exp_regs [32];
  int f_rs [16], f_rt [16], f_rd [16];
  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_instr(input int idx, input int rs, input int rt, input int rd, input bit score);
    logic [31:0] sum;
    imem[idx] = {6'd0, 5'(rs), 5'(rt), 5'(rd), 11'h020};
    f_rs[idx] = rs; f_rt[idx] = rt; f_rd[idx] = rd;
    if (score) begin
      sum = exp_regs[rs] + exp_regs[rt];
      exp_regs[rd] = sum;
      sbq.push_back('{rd: 5'(rd), val: sum, pc: 32'(4 * (idx + 1))});
    end
  endtask

  // Monitor: checks the register file one cycle after each writeback strobe (R9)
  bit wb_pend = 0;
  always @(negedge clk) begin
    if (wb_pend) begin
      wb_pend = 0;
      if (sbq.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9 actual=writeback expected=none");
      end else begin
        sb_t it;
        it = sbq.pop_front();
        chk("R9 sum", regs[it.rd], it.val);
        chk("R9 pc", pc, it.pc);
      end
    end
    if (!rst && wr_en_o[0]) wb_pend = 1;
  end

  task automatic step_checks(input int k, input int ins, input string seqreq);
    logic [7:0] ew, es;
    ew = (k < 8) ? (8'h80 >> k) : 8'h00;
    es = (k < 8) ? (8'h01 << k) : 8'h00;
    chk(seqreq, upc_o, k);
    chk("R4 wr", wr_en_o, ew);
    chk("R4 src", src_en_o, es);
    if (k == 4) begin
      chk("R7 rs", rs_o, f_rs[ins]);
      chk("R7 rt", rt_o, f_rt[ins]);
      chk("R7 rd", rd_o, f_rd[ins]);
      chk("R8 wa=rt", wa_o, f_rt[ins]);
    end
    if (k == 7) chk("R8 wa=rd", wa_o, f_rd[ins]);
  endtask

  initial begin
    int step, ins;
    for (int i = 0; i < 32; i++) begin
      regs[i] = 32'(i) * 32'h0101_0101 + 32'd3;
    end
    regs[9]  = 32'hFFFF_FFF0;
    regs[10] = 32'h0000_0020;
    for (int i = 0; i < 32; i++) exp_regs[i] = regs[i];
    for (int i = 0; i < 16; i++) imem[i] = 32'h0;
    pc = 0; mar = 0; mdr = 0; a_q = 0; b_q = 0; alu_q = 0;

    put_instr(0, 1, 2, 3, 1);
    put_instr(1, 3, 3, 4, 1);    // rs == rt
    put_instr(2, 4, 5, 4, 1);    // rd == rs
    put_instr(3, 31, 30, 31, 1);
    put_instr(4, 0, 1, 5, 1);
    put_instr(5, 9, 10, 11, 1);  // wraps past 2^32
    put_instr(6, 6, 7, 8, 1);
    put_instr(7, 11, 11, 12, 1);
    put_instr(8, 12, 2, 2, 1);   // rd == rt
    put_instr(9, 20, 21, 22, 1);
    put_instr(10, 13, 14, 15, 0); // aborted by reset
    put_instr(11, 16, 17, 18, 1);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 upc", upc_o, 0);
    chk("R1 wr", wr_en_o, 0);
    chk("R1 src", src_en_o, 0);
    chk("R6 ir reset", {rs_o, rt_o, rd_o}, 0);

    @(posedge clk); #1 rst = 1'b0;
    step = 0; ins = 0;
    for (int c = 0; c < NI * 9; c++) begin
      @(negedge clk);
      step_checks(step, ins, (c > 0 && step == 0) ? "R3" : "R2");
      if (step == 2) begin
        // Before the load edge the IR still holds the previous word
        chk("R6 hold", rs_o, (ins == 0) ? 0 : f_rs[ins - 1]);
        chk("R6 hold", rd_o, (ins == 0) ? 0 : f_rd[ins - 1]);
      end
      if (step == 8) begin step = 0; ins++; end
      else step++;
    end

    // Mid-routine reset during step 5 of instruction 10
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      step_checks(k, 10, k == 0 ? "R3" : "R2");
    end
    @(posedge clk); #1 rst = 1'b1;
    @(negedge clk);
    chk("R1 wr mid", wr_en_o, 0);
    chk("R1 src mid", src_en_o, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 upc mid", upc_o, 0);
    @(posedge clk); #1 rst = 1'b0;
    chk("R1 no writeback", regs[15], exp_regs[15]);

    // Restart at fetch with instruction 11
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      step_checks(k, 11, k == 0 ? "R1 restart" : "R2");
    end
    repeat (2) @(negedge clk);
    chk("R9 queue drained", sbq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule